// File: doc/BRIEF.md
# Supply-Aware CAN Bus State Controller

This block is the digital decision core of the bus side of a CAN physical-layer model. Each clock it takes the transmit bit with its validity flag, the logic-side and bus-side power-good flags, a signed die temperature in degrees Celsius and a signed differential bus voltage in millivolts. From these it decides whether the two line drivers are enabled (dominant) or released (recessive) and what the receive bit is. It also reports whether thermal shutdown is active and produces a bus-power sense output that is low while bus power is present.

The drivers are enabled only when four things hold together: both supplies are good, the transmit input is valid and low, and the die is not in thermal shutdown. Thermal shutdown has hysteresis, so the drivers stay off until the die has cooled well below the trip point. The receiver decodes the differential voltage with two thresholds and holds its last decision inside the band between them.

The power-sense output follows the bus-power flag only after a run of consistent samples. The enable delay and the disable delay are separate parameters in clock cycles, so short power-good pulses are filtered out. All outputs are registered and take their value at the clock edge where the inputs are sampled.

Top module: `can_bus_ctrl`

## Requirements
- R1: With `vlogic_ok`=1, `vbus_ok`=1, `txd_valid`=1, `txd`=0 and no thermal shutdown decided at that edge, `canh_en` and `canl_en` are both 1 after that clock edge.
- R2: With `txd`=1 or `txd_valid`=0, `canh_en` and `canl_en` are both 0 (recessive) after the edge.
- R3: With `vlogic_ok`=0 and `vbus_ok`=1, both drive enables are 0 whatever `txd` is.
- R4: While bus power is present, a differential voltage of at least 900 mV drives `rxd` to 0, and one of at most 500 mV drives `rxd` to 1, after the edge.
- R5: A differential voltage strictly between 500 mV and 900 mV leaves `rxd` at its previous value.
- R6: A die temperature of 150 or more sets `tsd_active` to 1 and forces both drive enables to 0 at the same edge.
- R7: Once set, `tsd_active` stays 1 until the temperature is 140 or less; at the edge where it clears, a dominant request drives the enables again.
- R8: The receiver keeps decoding per R4 and R5 while `tsd_active` is 1.
- R9: With `vbus_ok`=0, both drive enables are 0, `rxd` is 1 and the receiver's held state returns to recessive.
- R10: `bus_sense_n` falls to 0 after `ON_DLY` consecutive edges with `vbus_ok`=1, and rises to 1 after `OFF_DLY` consecutive edges with `vbus_ok`=0.
- R11: A run of `vbus_ok` shorter than the relevant delay does not change `bus_sense_n`.
- R12: During and after reset, `canh_en`=0, `canl_en`=0, `rxd`=1, `bus_sense_n`=1 and `tsd_active`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txd | input | 1 | Transmit bit, 0 requests dominant |
| txd_valid | input | 1 | Transmit input is driven (0 means floating) |
| vlogic_ok | input | 1 | Logic-side supply good |
| vbus_ok | input | 1 | Bus-side supply good |
| die_temp | input | TW | Signed die temperature, degrees Celsius |
| bus_diff_mv | input | DW | Signed CANH minus CANL voltage, millivolts |
| canh_en | output | 1 | High-side driver enable |
| canl_en | output | 1 | Low-side driver enable |
| rxd | output | 1 | Receive bit, 0 for dominant |
| bus_sense_n | output | 1 | Bus-power sense, 0 when bus power is present |
| tsd_active | output | 1 | Thermal shutdown in force |

## Verification
The thermal trip and a dominant transmit request can land on the same edge, and so can loss of bus power and a dominant level on the receive input. The bench steps the temperature onto exactly 150 and back onto exactly 140 while holding `txd` low, and drops `vbus_ok` while the differential voltage stays above 900 mV. A reference model in the bench, built from the requirements, judges every edge. The random phase then mixes temperatures around both thresholds with voltages around both receiver limits and runs of bus power of varying length, so that these meetings also happen by chance.

// File: rtl/can_ctrl_pkg.sv
package can_ctrl_pkg;
  typedef enum logic {
    LVL_RECESSIVE = 1'b0,
    LVL_DOMINANT  = 1'b1
  } bus_lvl_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/can_rx_slicer.sv
module can_rx_slicer
  import can_ctrl_pkg::*;
#(
  parameter int DW     = 16,
  parameter int DOM_MV = 900,
  parameter int REC_MV = 500
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_ok,
  input  logic signed [DW-1:0] diff_mv,
  output bus_lvl_e             lvl_q
);
  localparam logic signed [DW-1:0] DOM_T = DW'(DOM_MV);
  localparam logic signed [DW-1:0] REC_T = DW'(REC_MV);

  bus_lvl_e lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (!bus_ok) begin
      lvl_d = LVL_RECESSIVE;
    end else if (diff_mv >= DOM_T) begin
      lvl_d = LVL_DOMINANT;
    end else if (diff_mv <= REC_T) begin
      lvl_d = LVL_RECESSIVE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= LVL_RECESSIVE;
    else     lvl_q <= lvl_d;
  end
endmodule

// File: rtl/can_thermal_guard.sv
module can_thermal_guard #(
  parameter int TW       = 10,
  parameter int TRIP_C   = 150,
  parameter int CLEAR_C  = 140
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [TW-1:0] temp_c,
  output logic                 trip_d,
  output logic                 trip_q
);
  localparam logic signed [TW-1:0] TRIP_T  = TW'(TRIP_C);
  localparam logic signed [TW-1:0] CLEAR_T = TW'(CLEAR_C);

  always_comb begin
    trip_d = trip_q;
    if (temp_c >= TRIP_T)       trip_d = 1'b1;
    else if (temp_c <= CLEAR_T) trip_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) trip_q <= 1'b0;
    else     trip_q <= trip_d;
  end
endmodule

// File: rtl/can_psense_seq.sv
module can_psense_seq
  import can_ctrl_pkg::*;
#(
  parameter int unsigned ON_DLY  = 300,
  parameter int unsigned OFF_DLY = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic vbus_ok,
  output logic present_q
);
  localparam int unsigned MAXD = max_u(max_u(ON_DLY, OFF_DLY), 2);
  localparam int          CW   = $clog2(MAXD + 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_DLY - 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_DLY - 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] last;
  logic          mismatch;

  assign mismatch = (vbus_ok != present_q);
  assign last     = present_q ? OFF_LAST : ON_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      present_q <= 1'b0;
      run_q     <= '0;
    end else if (!mismatch) begin
      run_q <= '0;
    end else if (run_q == last) begin
      present_q <= vbus_ok;
      run_q     <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/can_bus_ctrl.sv
module can_bus_ctrl
  import can_ctrl_pkg::*;
#(
  parameter int          TW      = 10,
  parameter int          DW      = 16,
  parameter int          DOM_MV  = 900,
  parameter int          REC_MV  = 500,
  parameter int          TRIP_C  = 150,
  parameter int          CLEAR_C = 140,
  parameter int unsigned ON_DLY  = 300,
  parameter int unsigned OFF_DLY = 1000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 txd,
  input  logic                 txd_valid,
  input  logic                 vlogic_ok,
  input  logic                 vbus_ok,
  input  logic signed [TW-1:0] die_temp,
  input  logic signed [DW-1:0] bus_diff_mv,
  output logic                 canh_en,
  output logic                 canl_en,
  output logic                 rxd,
  output logic                 bus_sense_n,
  output logic                 tsd_active
);
  bus_lvl_e rx_lvl;
  logic     trip_d;
  logic     trip_q;
  logic     present;
  logic     drive_req;
  logic     drive_q;

  can_rx_slicer #(.DW(DW), .DOM_MV(DOM_MV), .REC_MV(REC_MV)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .bus_ok  (vbus_ok),
    .diff_mv (bus_diff_mv),
    .lvl_q   (rx_lvl)
  );

  can_thermal_guard #(.TW(TW), .TRIP_C(TRIP_C), .CLEAR_C(CLEAR_C)) u_tsd (
    .clk    (clk),
    .rst    (rst),
    .temp_c (die_temp),
    .trip_d (trip_d),
    .trip_q (trip_q)
  );

  can_psense_seq #(.ON_DLY(ON_DLY), .OFF_DLY(OFF_DLY)) u_sense (
    .clk       (clk),
    .rst       (rst),
    .vbus_ok   (vbus_ok),
    .present_q (present)
  );

  assign drive_req = vlogic_ok & vbus_ok & txd_valid & ~txd & ~trip_d;

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= drive_req;
  end

  assign canh_en     = drive_q;
  assign canl_en     = drive_q;
  assign rxd         = (rx_lvl == LVL_RECESSIVE);
  assign tsd_active  = trip_q;
  assign bus_sense_n = ~present;
endmodule

// File: rtl/can_bus_ctrl_chk.sv
module can_bus_ctrl_chk #(
  parameter int TW      = 10,
  parameter int DW      = 16,
  parameter int DOM_MV  = 900,
  parameter int TRIP_C  = 150
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 vlogic_ok,
  input logic                 vbus_ok,
  input logic signed [TW-1:0] die_temp,
  input logic signed [DW-1:0] bus_diff_mv,
  input logic                 canh_en,
  input logic                 canl_en,
  input logic                 rxd,
  input logic                 bus_sense_n,
  input logic                 tsd_active
);
  p_pair_matches_r1: assert property (@(posedge clk) disable iff (rst)
    canh_en == canl_en);

  p_logic_off_recessive_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(vlogic_ok) |-> !canh_en);

  p_shutdown_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    tsd_active |-> (!canh_en && !canl_en));

  p_hot_trips_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(die_temp) >= TW'(TRIP_C))) |-> tsd_active);

  p_rx_dominant_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(vbus_ok) && ($past(bus_diff_mv) >= DW'(DOM_MV))) |-> !rxd);

  p_bus_absent_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(vbus_ok) |-> (rxd && !canh_en));

  p_sense_follows_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(bus_sense_n) |-> ($past(vbus_ok) == !bus_sense_n));
endmodule

bind can_bus_ctrl can_bus_ctrl_chk #(
  .TW(TW), .DW(DW), .DOM_MV(DOM_MV), .TRIP_C(TRIP_C)
) u_chk (
  .clk(clk), .rst(rst), .vlogic_ok(vlogic_ok), .vbus_ok(vbus_ok),
  .die_temp(die_temp), .bus_diff_mv(bus_diff_mv), .canh_en(canh_en),
  .canl_en(canl_en), .rxd(rxd), .bus_sense_n(bus_sense_n),
  .tsd_active(tsd_active)
);

// File: tb/sim_can_bus_ctrl.sv
`timescale 1ns/1ps
module sim_can_bus_ctrl;
  localparam int TW = 10;
  localparam int DW = 16;
  localparam int ON_D  = 8;
  localparam int OFF_D = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txd = 1'b1, txd_valid = 1'b1, vlogic_ok = 1'b1, vbus_ok = 1'b0;
  logic signed [TW-1:0] die_temp = 10'sd25;
  logic signed [DW-1:0] bus_diff_mv = '0;
  logic canh_en, canl_en, rxd, bus_sense_n, tsd_active;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  bit m_tsd, m_dom, m_up, m_drv;
  int m_cnt;

  always #5 clk = ~clk;

  can_bus_ctrl #(.TW(TW), .DW(DW), .ON_DLY(ON_D), .OFF_DLY(OFF_D)) u0 (
    .clk(clk), .rst(rst), .txd(txd), .txd_valid(txd_valid),
    .vlogic_ok(vlogic_ok), .vbus_ok(vbus_ok), .die_temp(die_temp),
    .bus_diff_mv(bus_diff_mv), .canh_en(canh_en), .canl_en(canl_en),
    .rxd(rxd), .bus_sense_n(bus_sense_n), .tsd_active(tsd_active)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string drv_tag(input bit t, input bit v, input bit vl, input bit vb);
    if (!vb) return "R9";
    if (!vl) return "R3";
    if (m_tsd) return "R6";
    if (v && !t) return "R1";
    return "R2";
  endfunction

  task automatic model_step();
    int lim;
    if (die_temp >= 150) m_tsd = 1;
    else if (die_temp <= 140) m_tsd = 0;
    if (!vbus_ok) m_dom = 0;
    else if (bus_diff_mv >= 900) m_dom = 1;
    else if (bus_diff_mv <= 500) m_dom = 0;
    m_drv = vlogic_ok && vbus_ok && txd_valid && !txd && !m_tsd;
    if (vbus_ok != m_up) begin
      lim = m_up ? OFF_D : ON_D;
      if (m_cnt == lim - 1) begin m_up = vbus_ok; m_cnt = 0; end
      else m_cnt++;
    end else m_cnt = 0;
  endtask

  // apply inputs at falling edge, then compare after the next rising edge
  task automatic step(input bit t, input bit v, input bit vl, input bit vb,
                      input int temp, input int diff);
    string rtag;
    @(negedge clk);
    txd = t; txd_valid = v; vlogic_ok = vl; vbus_ok = vb;
    die_temp = TW'(temp); bus_diff_mv = DW'(diff);
    @(posedge clk);
    #1;
    model_step();
    chk(drv_tag(t, v, vl, vb), canh_en, m_drv);
    chk(drv_tag(t, v, vl, vb), canl_en, m_drv);
    if (!vb) rtag = "R9";
    else if (m_tsd) rtag = "R8";
    else if (diff > 500 && diff < 900) rtag = "R5";
    else rtag = "R4";
    chk(rtag, rxd, !m_dom);
    chk((temp > 140 && temp < 150) ? "R7" : "R6", tsd_active, m_tsd);
    chk("R10", bus_sense_n, !m_up);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    chk("R12", canh_en, 0); chk("R12", canl_en, 0); chk("R12", rxd, 1);
    chk("R12", bus_sense_n, 1); chk("R12", tsd_active, 0);
    @(negedge clk); rst = 1'b0;
    m_tsd = 0; m_dom = 0; m_up = 0; m_cnt = 0; m_drv = 0;

    // R10: power up takes ON_D edges
    for (int i = 0; i < ON_D - 1; i++) step(1, 1, 1, 1, 25, 0);
    chk("R10", bus_sense_n, 1);
    step(1, 1, 1, 1, 25, 0);
    chk("R10", bus_sense_n, 0);

    // R1 / R2: dominant and recessive, floating input
    step(0, 1, 1, 1, 25, 0);  chk("R1", canh_en, 1);
    step(1, 1, 1, 1, 25, 0);  chk("R2", canl_en, 0);
    step(0, 0, 1, 1, 25, 0);  chk("R2", canh_en, 0);
    // R3: logic supply off
    step(0, 1, 0, 1, 25, 0);  chk("R3", canh_en, 0);

    // R4 / R5: thresholds and hold band, both directions
    step(1, 1, 1, 1, 25, 900);  chk("R4", rxd, 0);
    step(1, 1, 1, 1, 25, 899);  chk("R5", rxd, 0);
    step(1, 1, 1, 1, 25, 501);  chk("R5", rxd, 0);
    step(1, 1, 1, 1, 25, 500);  chk("R4", rxd, 1);
    step(1, 1, 1, 1, 25, 700);  chk("R5", rxd, 1);

    // R6 / R7 / R8: trip on the same edge as a dominant request
    step(0, 1, 1, 1, 149, 1000); chk("R1", canh_en, 1);
    step(0, 1, 1, 1, 150, 1000); chk("R6", canh_en, 0); chk("R6", tsd_active, 1);
    chk("R8", rxd, 0);
    step(0, 1, 1, 1, 141, 0);    chk("R7", tsd_active, 1); chk("R8", rxd, 1);
    step(0, 1, 1, 1, 140, 0);    chk("R7", tsd_active, 0); chk("R7", canh_en, 1);

    // R9 / R11: bus loss while receiving dominant, short glitch
    step(0, 1, 1, 1, 25, 1200);  chk("R4", rxd, 0);
    step(0, 1, 1, 0, 25, 1200);  chk("R9", rxd, 1); chk("R9", canh_en, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 25, 1200);
    step(1, 1, 1, 1, 25, 700);   chk("R9", rxd, 1); chk("R11", bus_sense_n, 0);
    // R10: full power-off run
    for (int i = 0; i < OFF_D; i++) step(1, 1, 1, 0, 25, 0);
    chk("R10", bus_sense_n, 1);
    // R11: short power-present pulse
    for (int i = 0; i < ON_D - 2; i++) step(1, 1, 1, 1, 25, 0);
    step(1, 1, 1, 0, 25, 0);     chk("R11", bus_sense_n, 1);

    // random phase
    begin
      bit vb = 1'b1;
      for (int i = 0; i < 6000; i++) begin
        int temp, diff;
        if ($urandom_range(0, 39) == 0) vb = ~vb;
        temp = $urandom_range(130, 160);
        diff = int'($urandom_range(0, 1500)) - 200;
        step($urandom_range(0, 1), $urandom_range(0, 7) != 0,
             $urandom_range(0, 9) != 0, vb, temp, diff);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule